// File: doc/BRIEF.md
# Programmable Clock Output Router

This block sits behind a frequency synthesizer and turns its clocks into two output clocks. It runs on the fast oscillator clock and treats the reference clock as a sampled input. A post divider divides by twice a programmable value. A selection network feeds a main clock output and a secondary clock output. The secondary output leaves through a multifunction pin, and the same pin can instead serve as an output-enable input or as a power-down input.

Two configuration words are held as static inputs, and a frequency-select input picks one of them. A change of bank is applied only when the divider that feeds the main output ends a full period, so switching happens on the fly without short pulses. In each configuration word the synthesizer's input-divider and feedback-divider values sit beside the post-divide value. This block carries them unused and only the post-divide value and the two selects affect its outputs.

Top module: `clkrt_router`

## Requirements
- R1: With main select code 0, `clk0_out` is the oscillator clock divided by 2*P. It is high for P `clk` cycles and then low for P `clk` cycles. P is bits [4:0] of the active configuration word.
- R2: A P field of 0 behaves exactly like P = 1, so the output toggles on every `clk` cycle.
- R3: The main select is bits [6:5]. Code 1 selects the sampled reference. Code 2 selects the reference divided by 2*P, where the divider counts rising edges of `ref_in`. Code 3 behaves like code 0.
- R4: The secondary select is bits [8:7]. Code 0 selects the sampled reference, 1 the reference divided by 2, 2 the main source and 3 the main source divided by 2. It reaches `mf_pin_out` only in the clock role, and `mf_pin_out` stays 0 in every other role.
- R5: When `fsel` is 1, bank 1 (`cfg_bank1`) is chosen. When `fsel` is 0, bank 2 (`cfg_bank2`) is chosen. Bits [16:9] and [27:17] hold the input-divider and feedback-divider values and have no effect on any output.
- R6: A changed `fsel` takes effect only in the cycle where the divider feeding the main output drives its output from 1 to 0. That divider is the reference divider for main select code 2 and the oscillator divider for every other code. Reset and power-down also load the chosen bank.
- R7: `mf_role` code 0 is output-enable, 1 is power-down, 2 is clock output and 3 behaves like 0. `mf_pin_oe` is 1 only in the clock role.
- R8: In the output-enable role, a 0 on `mf_pin_in` forces both outputs to 0 while the dividers keep counting. A 1 on the pin gives normal operation.
- R9: In the power-down role, a 0 on `mf_pin_in` clears every divider and forces the outputs to 0. After the pin returns to 1, all dividers restart from zero.
- R10: After a synchronous reset `rst`, both outputs are 0 and all dividers start from zero.
- R11: Each output is registered, so an output takes the value its source had one `clk` cycle earlier. The sampled reference therefore lags `ref_in` by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, drives all logic |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, sampled on `clk` |
| fsel | input | 1 | Bank select: 1 = bank 1, 0 = bank 2 |
| cfg_bank1 | input | 28 | Configuration word of bank 1 |
| cfg_bank2 | input | 28 | Configuration word of bank 2 |
| mf_role | input | 2 | Role of the multifunction pin |
| mf_pin_in | input | 1 | Value received on the multifunction pin |
| clk0_out | output | 1 | Main clock output |
| mf_pin_out | output | 1 | Value driven on the multifunction pin |
| mf_pin_oe | output | 1 | Drive enable of the multifunction pin |

## Verification
The bench switches `fsel` in the middle of a divider count, with banks that differ in P and in source. A design that applied the new bank at once would show a high or low phase shorter than either P. A P of zero is exercised, and a divider that compared against P-1 without guarding it would stall or wrap for 32 cycles. Banks that differ only in the carried divider fields are alternated, which exposes any decode that leaks those bits into the post-divide value. Power-down pulses are followed by release, and a design whose counters resume from their old value instead of zero would drift from the reference model's phase.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;

    localparam int P_W    = 5;
    localparam int R_W    = 8;
    localparam int M_W    = 11;
    localparam int SEL_W  = 2;
    localparam int ROLE_W = 2;

    localparam int P_LSB  = 0;
    localparam int MS_LSB = P_LSB + P_W;
    localparam int AS_LSB = MS_LSB + SEL_W;
    localparam int R_LSB  = AS_LSB + SEL_W;
    localparam int M_LSB  = R_LSB + R_W;
    localparam int CFG_W  = M_LSB + M_W;

    localparam int NDIV    = 2;
    localparam int OSC_IDX = 0;
    localparam int REF_IDX = 1;
    localparam int NHALF   = 2;
    localparam int RH_IDX  = 0;
    localparam int MH_IDX  = 1;

    typedef enum logic [SEL_W-1:0] {
        MAIN_OSC     = 2'd0,
        MAIN_REF     = 2'd1,
        MAIN_REFDIV  = 2'd2,
        MAIN_OSC_ALT = 2'd3
    } main_sel_e;

    typedef enum logic [SEL_W-1:0] {
        AUX_REF       = 2'd0,
        AUX_REF_HALF  = 2'd1,
        AUX_MAIN      = 2'd2,
        AUX_MAIN_HALF = 2'd3
    } aux_sel_e;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_OE     = 2'd0,
        ROLE_PD     = 2'd1,
        ROLE_CLK    = 2'd2,
        ROLE_OE_ALT = 2'd3
    } role_e;

    typedef struct packed {
        logic [P_W-1:0] p;
        main_sel_e      msel;
        aux_sel_e       asel;
    } live_cfg_t;

    localparam int LIVE_W = $bits(live_cfg_t);

    typedef struct packed {
        logic gate_en;
        logic halt;
        logic drive_pin;
    } pin_ctl_t;

    function automatic logic [P_W-1:0] eff_div(input logic [P_W-1:0] p);
        return (p == '0) ? P_W'(1) : p;
    endfunction

    function automatic pin_ctl_t decode_role(input role_e r, input logic pin);
        pin_ctl_t c;
        logic oe_off;
        oe_off      = ((r == ROLE_OE) || (r == ROLE_OE_ALT)) && !pin;
        c.halt      = (r == ROLE_PD) && !pin;
        c.gate_en   = !oe_off && !c.halt;
        c.drive_pin = (r == ROLE_CLK);
        return c;
    endfunction

endpackage

// File: rtl/clkrt_postdiv.sv
module clkrt_postdiv #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] divv,
    output logic         out_q,
    output logic         fall_evt
);
    logic [W-1:0] cnt_q;
    logic         term;

    assign term     = (cnt_q >= (divv - W'(1)));
    assign fall_evt = tick && term && out_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (tick) begin
            if (term) begin
                cnt_q <= '0;
                out_q <= !out_q;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end
endmodule

// File: rtl/clkrt_halfdiv.sv
module clkrt_halfdiv (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic out_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_q <= 1'b0;
        end else if (tick) begin
            out_q <= !out_q;
        end
    end
endmodule

// File: rtl/clkrt_bank.sv
module clkrt_bank
    import clkrt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      fsel,
    input  live_cfg_t bank_a,
    input  live_cfg_t bank_b,
    output live_cfg_t act_q
);
    live_cfg_t chosen;

    assign chosen = fsel ? bank_a : bank_b;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            act_q <= chosen;
        end
    end
endmodule

// File: rtl/clkrt_router.sv
module clkrt_router
    import clkrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fsel,
    input  logic [CFG_W-1:0] cfg_bank1,
    input  logic [CFG_W-1:0] cfg_bank2,
    input  logic [ROLE_W-1:0] mf_role,
    input  logic             mf_pin_in,
    output logic             clk0_out,
    output logic             mf_pin_out,
    output logic             mf_pin_oe
);
    live_cfg_t      cfg_a;
    live_cfg_t      cfg_b;
    live_cfg_t      act_q;
    pin_ctl_t       pc;
    logic [P_W-1:0] div_val;
    logic           ref_q;
    logic           ref_rise;
    logic           main_src;
    logic           main_prev;
    logic           main_rise;
    logic           aux_src;
    logic           bank_load;
    logic           clk0_q;
    logic           clk1_q;
    logic [NDIV-1:0]  div_tick;
    logic [NDIV-1:0]  div_out;
    logic [NDIV-1:0]  div_fall;
    logic [NHALF-1:0] half_tick;
    logic [NHALF-1:0] half_out;

    // stored word layout: post value, main select, secondary select, then carried dividers
    assign cfg_a.p    = cfg_bank1[P_LSB +: P_W];
    assign cfg_a.msel = main_sel_e'(cfg_bank1[MS_LSB +: SEL_W]);
    assign cfg_a.asel = aux_sel_e'(cfg_bank1[AS_LSB +: SEL_W]);
    assign cfg_b.p    = cfg_bank2[P_LSB +: P_W];
    assign cfg_b.msel = main_sel_e'(cfg_bank2[MS_LSB +: SEL_W]);
    assign cfg_b.asel = aux_sel_e'(cfg_bank2[AS_LSB +: SEL_W]);

    assign pc = decode_role(role_e'(mf_role), mf_pin_in);

    // bank switch waits for the falling edge of the divider that feeds the main output
    assign bank_load = pc.halt ||
                       ((act_q.msel == MAIN_REFDIV) ? div_fall[REF_IDX] : div_fall[OSC_IDX]);

    clkrt_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (bank_load),
        .fsel   (fsel),
        .bank_a (cfg_a),
        .bank_b (cfg_b),
        .act_q  (act_q)
    );

    assign div_val = eff_div(act_q.p);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
        end
    end

    assign ref_rise = ref_in && !ref_q;

    assign div_tick[OSC_IDX] = 1'b1;
    assign div_tick[REF_IDX] = ref_rise;

    for (genvar gi = 0; gi < NDIV; gi++) begin : g_div
        clkrt_postdiv #(.W(P_W)) u_div (
            .clk      (clk),
            .rst      (rst),
            .clr      (pc.halt),
            .tick     (div_tick[gi]),
            .divv     (div_val),
            .out_q    (div_out[gi]),
            .fall_evt (div_fall[gi])
        );
    end

    always_comb begin
        unique case (act_q.msel)
            MAIN_REF:    main_src = ref_q;
            MAIN_REFDIV: main_src = div_out[REF_IDX];
            default:     main_src = div_out[OSC_IDX];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pc.halt) begin
            main_prev <= 1'b0;
        end else begin
            main_prev <= main_src;
        end
    end

    assign main_rise = main_src && !main_prev;

    assign half_tick[RH_IDX] = ref_rise;
    assign half_tick[MH_IDX] = main_rise;

    for (genvar hi = 0; hi < NHALF; hi++) begin : g_half
        clkrt_halfdiv u_half (
            .clk   (clk),
            .rst   (rst),
            .clr   (pc.halt),
            .tick  (half_tick[hi]),
            .out_q (half_out[hi])
        );
    end

    always_comb begin
        unique case (act_q.asel)
            AUX_REF:      aux_src = ref_q;
            AUX_REF_HALF: aux_src = half_out[RH_IDX];
            AUX_MAIN:     aux_src = main_src;
            default:      aux_src = half_out[MH_IDX];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pc.halt) begin
            clk0_q <= 1'b0;
            clk1_q <= 1'b0;
        end else begin
            clk0_q <= main_src && pc.gate_en;
            clk1_q <= aux_src && pc.gate_en && pc.drive_pin;
        end
    end

    assign clk0_out   = clk0_q;
    assign mf_pin_out = clk1_q;
    assign mf_pin_oe  = pc.drive_pin;
endmodule

// File: rtl/clkrt_chk.sv
module clkrt_chk
    import clkrt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_bank1,
    input logic [CFG_W-1:0]  cfg_bank2,
    input logic [ROLE_W-1:0] mf_role,
    input logic              mf_pin_in,
    input logic              clk0_out,
    input logic              mf_pin_out,
    input logic [LIVE_W-1:0] act_v,
    input logic              bank_load
);
    logic pd_now;
    logic oe_off;

    assign pd_now = (mf_role == ROLE_PD) && !mf_pin_in;
    assign oe_off = ((mf_role == ROLE_OE) || (mf_role == ROLE_OE_ALT)) && !mf_pin_in;

    AST_CFG_STATIC: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_bank1) && $stable(cfg_bank2) && $stable(mf_role)); // R5

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_v) |-> ($past(bank_load) || $past(pd_now) || $past(rst))); // R6

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mf_role != ROLE_CLK) |=> !mf_pin_out); // R4

    AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
        oe_off |=> (!clk0_out && !mf_pin_out)); // R8

    AST_PD_GATE: assert property (@(posedge clk) disable iff (rst)
        pd_now |=> (!clk0_out && !mf_pin_out)); // R9
endmodule

bind clkrt_router clkrt_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_bank1  (cfg_bank1),
    .cfg_bank2  (cfg_bank2),
    .mf_role    (mf_role),
    .mf_pin_in  (mf_pin_in),
    .clk0_out   (clk0_out),
    .mf_pin_out (mf_pin_out),
    .act_v      (act_q),
    .bank_load  (bank_load)
);

// File: tb/clkrt_router_tb_top.sv
module clkrt_router_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        fsel = 1'b1;
    logic [27:0] cfg_bank1 = '0;
    logic [27:0] cfg_bank2 = '0;
    logic [1:0]  mf_role = 2'd2;
    logic        mf_pin_in = 1'b1;
    logic        clk0_out;
    logic        mf_pin_out;
    logic        mf_pin_oe;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R10";

    // behavioural reference state
    int  m_p, m_ms, m_as;
    int  m_oc, m_rc;
    bit  m_oq, m_rq, m_rpq, m_r2q, m_mprev, m_m2q, m_c0, m_c1;
    int  run_k = 0;

    always #4 clk = !clk;

    clkrt_router dut_i (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .fsel       (fsel),
        .cfg_bank1  (cfg_bank1),
        .cfg_bank2  (cfg_bank2),
        .mf_role    (mf_role),
        .mf_pin_in  (mf_pin_in),
        .clk0_out   (clk0_out),
        .mf_pin_out (mf_pin_out),
        .mf_pin_oe  (mf_pin_oe)
    );

    function automatic logic [27:0] mk_cfg(int p, int ms, int as_, int r, int m);
        logic [27:0] v;
        v = {m[10:0], r[7:0], as_[1:0], ms[1:0], p[4:0]};
        return v;
    endfunction

    task automatic model_step();
        logic [27:0] w;
        int  sp, sms, sas, pe;
        bit  pd, en, rise, ofall, rpfall, load, msv, asv;
        w   = fsel ? cfg_bank1 : cfg_bank2;
        sp  = int'(w[4:0]);
        sms = int'(w[6:5]);
        sas = int'(w[8:7]);
        pd  = (mf_role == 2'd1) && !mf_pin_in;
        en  = !(((mf_role == 2'd0) || (mf_role == 2'd3)) && !mf_pin_in) && !pd;
        pe  = (m_p == 0) ? 1 : m_p;
        msv = (m_ms == 1) ? m_rq : (m_ms == 2) ? m_rpq : m_oq;
        asv = (m_as == 0) ? m_rq : (m_as == 1) ? m_r2q : (m_as == 2) ? msv : m_m2q;
        rise   = ref_in && !m_rq;
        ofall  = (m_oc >= pe - 1) && m_oq;
        rpfall = rise && (m_rc >= pe - 1) && m_rpq;
        load   = (m_ms == 2) ? rpfall : ofall;
        if (rst || pd) begin
            m_oc = 0; m_oq = 0; m_rc = 0; m_rpq = 0; m_r2q = 0;
            m_mprev = 0; m_m2q = 0; m_c0 = 0; m_c1 = 0;
            m_p = sp; m_ms = sms; m_as = sas;
            m_rq = rst ? 1'b0 : ref_in;
        end else begin
            if (load) begin
                m_p = sp; m_ms = sms; m_as = sas;
            end
            if (m_oc >= pe - 1) begin m_oc = 0; m_oq = !m_oq; end
            else m_oc = m_oc + 1;
            if (rise) begin
                if (m_rc >= pe - 1) begin m_rc = 0; m_rpq = !m_rpq; end
                else m_rc = m_rc + 1;
                m_r2q = !m_r2q;
            end
            if (msv && !m_mprev) m_m2q = !m_m2q;
            m_mprev = msv;
            m_c0 = msv && en;
            m_c1 = asv && en && (mf_role == 2'd2);
            m_rq = ref_in;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (clk0_out !== m_c0 || mf_pin_out !== m_c1 || mf_pin_oe !== (mf_role == 2'd2)) begin
            fails++;
            $display("FAIL %s clk0=%0b/%0b pin=%0b/%0b oe=%0b/%0b (actual/expected)",
                     cur_req, clk0_out, m_c0, mf_pin_out, m_c1, mf_pin_oe, (mf_role == 2'd2));
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [27:0] b1, logic [27:0] b2, logic [1:0] role, logic fs);
        rst = 1'b1; ref_in = 1'b0;
        cfg_bank1 = b1; cfg_bank2 = b2; mf_role = role; fsel = fs; mf_pin_in = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        run_k = 0;
        check_bit("R10 clk0 after reset", clk0_out, 1'b0);
        check_bit("R10 pin after reset", mf_pin_out, 1'b0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            ref_in = ((run_k * 5) % 13) < 6;
            run_k++;
            tick();
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 R11: oscillator divided by 2*P, registered output
        cur_req = "R1";
        do_reset(mk_cfg(3, 0, 2, 0, 0), mk_cfg(3, 0, 2, 0, 0), 2'd2, 1'b1);
        check_bit("R7 pin drive in clock role", mf_pin_oe, 1'b1);
        run(60);
        cur_req = "R2";
        do_reset(mk_cfg(0, 0, 3, 0, 0), mk_cfg(0, 0, 3, 0, 0), 2'd2, 1'b1);
        run(30);
        // R3 R4 R11: reference-based sources
        cur_req = "R3/R4 ref";
        do_reset(mk_cfg(2, 1, 1, 0, 0), mk_cfg(2, 1, 1, 0, 0), 2'd2, 1'b1);
        run(80);
        cur_req = "R3/R4 refdiv";
        do_reset(mk_cfg(2, 2, 0, 0, 0), mk_cfg(2, 2, 0, 0, 0), 2'd2, 1'b1);
        run(80);
        cur_req = "R3 code3";
        do_reset(mk_cfg(4, 3, 3, 0, 0), mk_cfg(4, 3, 3, 0, 0), 2'd2, 1'b1);
        run(40);
        // R5 R6: bank switch mid-count
        cur_req = "R6";
        do_reset(mk_cfg(2, 0, 2, 17, 300), mk_cfg(5, 2, 2, 200, 1500), 2'd2, 1'b1);
        run(17); fsel = 1'b0; run(33); fsel = 1'b1; run(43); fsel = 1'b0; run(50);
        cur_req = "R5";
        do_reset(mk_cfg(3, 0, 3, 255, 2047), mk_cfg(3, 0, 3, 1, 5), 2'd2, 1'b0);
        for (int j = 0; j < 10; j++) begin fsel = !fsel; run(7); end
        // R7 R8: output-enable role, codes 0 and 3
        cur_req = "R8";
        do_reset(mk_cfg(2, 0, 2, 0, 0), mk_cfg(2, 0, 2, 0, 0), 2'd0, 1'b1);
        check_bit("R7 no drive in enable role", mf_pin_oe, 1'b0);
        run(10); mf_pin_in = 1'b0; run(12);
        check_bit("R8 clk0 held low", clk0_out, 1'b0);
        mf_pin_in = 1'b1; run(15);
        cur_req = "R7 code3";
        do_reset(mk_cfg(1, 0, 2, 0, 0), mk_cfg(1, 0, 2, 0, 0), 2'd3, 1'b1);
        check_bit("R7 no drive in code 3", mf_pin_oe, 1'b0);
        run(6); mf_pin_in = 1'b0; run(5);
        check_bit("R7 code 3 gates like enable", clk0_out, 1'b0);
        mf_pin_in = 1'b1; run(6);
        // R9: power-down and restart
        cur_req = "R9";
        do_reset(mk_cfg(3, 0, 0, 0, 0), mk_cfg(4, 2, 0, 0, 0), 2'd1, 1'b1);
        check_bit("R7 no drive in power-down role", mf_pin_oe, 1'b0);
        run(11); mf_pin_in = 1'b0; fsel = 1'b0; run(9);
        check_bit("R9 clk0 off in power-down", clk0_out, 1'b0);
        mf_pin_in = 1'b1; run(40);
        mf_pin_in = 1'b0; fsel = 1'b1; run(4); mf_pin_in = 1'b1; run(25);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule